// File: doc/BRIEF.md
# Fetch Branch Steering with Decode Resolution

This block sits beside the fetch stage of a five-stage pipeline and picks the address fetched in the next cycle. Branches are resolved in decode, so a wrong guess throws away only the single instruction fetched behind the branch. The block keeps a 16-entry table indexed by fetch address bits [5:2]. Each entry holds one direction bit, which is the last resolved outcome of a branch that mapped there, and the target that branch last went to. In predict mode a fetch whose entry says taken is steered straight to the stored target. A branch resolving in decode compares its real next address with the address the block guessed for it. On a mismatch the block raises a flush that turns the fetch/decode register into a no-op and redirects fetch.

In delay-slot mode the table is not consulted. The instruction behind a branch always runs, and a taken branch redirects fetch once its slot has been fetched. A flush never happens in this mode. The table is still trained in both modes. The surrounding pipeline owns the PC register: it feeds the chosen address back as the next fetch PC and clears its fetch/decode register when the flush is high.

Top module: `bpf_fetch_ctrl`

## Requirements
- R1: While reset is asserted, and after its release until a branch resolves, every table entry reads not-taken. `flush_o` and `upd_vld_o` stay 0, and `next_pc_o` equals `fetch_pc_i` + 4.
- R2: In predict mode (`slot_mode_i`=0), with no redirect and a fetch entry that reads not-taken, `next_pc_o` equals `fetch_pc_i` + 4.
- R3: A branch resolves in a cycle when `dec_br_i`=1 and the decode slot holds an instruction fetched in the previous cycle that was not flushed. In that cycle `upd_vld_o`=1, `upd_idx_o` equals bits [5:2] of the previous cycle's `fetch_pc_i`, and `upd_taken_o` equals `dec_taken_i`. `upd_vld_o` is 0 in every other cycle.
- R4: In predict mode, a fetch whose entry last recorded a taken outcome gets `next_pc_o` equal to that entry's stored target. An entry written at the clock edge that ends a resolve cycle is first seen by a fetch in the following cycle.
- R5: In predict mode, a resolving branch has a real next address: `dec_tgt_i` if taken, or the branch's PC + 4 if not taken. When this real next address differs from the address predicted for the branch at fetch, `flush_o`=1 in that same cycle and `next_pc_o` equals the real next address.
- R6: In predict mode, a resolving branch whose predicted next address was right gives `flush_o`=0 and leaves `next_pc_o` on the current fetch's prediction.
- R7: In the cycle after a flush, the instruction in decode is a no-op. A `dec_br_i`=1 in that cycle is ignored: no update, no flush and no redirect.
- R8: In delay-slot mode (`slot_mode_i`=1), `flush_o` is always 0. A resolving taken branch sets `next_pc_o` to `dec_tgt_i`. Otherwise `next_pc_o` is `fetch_pc_i` + 4, whatever the table holds.
- R9: In delay-slot mode the table is trained exactly as in R3.
- R10: A loop branch that is taken K-1 times and then falls through mispredicts on its first and last iteration of each visit, and on no iteration in between.
- R11: Fetch addresses that share bits [5:2] share one entry, so a branch is predicted from whatever the last aliasing branch recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_pc_i | input | PC_W | Address being fetched this cycle |
| dec_br_i | input | 1 | Instruction in decode is a conditional branch |
| dec_tgt_i | input | PC_W | Branch target computed in decode |
| dec_taken_i | input | 1 | Branch outcome from the decode comparator |
| slot_mode_i | input | 1 | 1 selects delay-slot mode, 0 selects predict mode |
| next_pc_o | output | PC_W | Address to fetch in the next cycle |
| flush_o | output | 1 | Clear the fetch/decode register to a no-op |
| upd_vld_o | output | 1 | Table entry is written this cycle |
| upd_idx_o | output | IDX_W | Index of the entry being written |
| upd_taken_o | output | 1 | Outcome written into that entry |

## Verification
The assertions take several things for granted. `fetch_pc_i` always follows the previous `next_pc_o`. `slot_mode_i` changes only across a reset. No branch sits in a delay slot. Decode target and outcome are stable for the whole cycle. The bench closes the loop itself: it feeds each chosen address back as the next fetch PC and applies a reset before every mode change. In delay-slot mode its programs place only plain instructions behind branches. It does keep driving the branch flag for a flushed slot, so the ignore path of R7 is exercised.

// File: rtl/bpf_pkg.sv
package bpf_pkg;
  typedef enum logic {
    FM_PREDICT = 1'b0,
    FM_SLOT    = 1'b1
  } fetch_mode_e;
endpackage

// File: rtl/bpf_pred_table.sv
module bpf_pred_table #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  output logic [PC_W-1:0]  rd_tgt_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_taken_i,
  input  logic [PC_W-1:0]  wr_tgt_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] taken_vec;
  logic [PC_W-1:0]  tgt_arr [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic            ent_taken_q;
    logic [PC_W-1:0] ent_tgt_q;
    logic            ent_we;

    assign ent_we = wr_en_i && (wr_idx_i == IDX_W'(e));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ent_taken_q <= 1'b0;
        ent_tgt_q   <= '0;
      end else if (ent_we) begin
        ent_taken_q <= wr_taken_i;
        // target kept from the last taken outcome only
        if (wr_taken_i) ent_tgt_q <= wr_tgt_i;
      end
    end

    assign taken_vec[e] = ent_taken_q;
    assign tgt_arr[e]   = ent_tgt_q;
  end

  assign rd_taken_o = taken_vec[rd_idx_i];
  assign rd_tgt_o   = tgt_arr[rd_idx_i];
endmodule

// File: rtl/bpf_resolve.sv
module bpf_resolve #(
  parameter int PC_W       = 32,
  parameter int INSN_BYTES = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] fetch_pc_i,
  input  logic [PC_W-1:0] fetch_npc_i,
  input  logic            kill_i,
  input  logic            dec_br_i,
  input  logic [PC_W-1:0] dec_tgt_i,
  input  logic            dec_taken_i,
  output logic            hit_o,
  output logic [PC_W-1:0] act_npc_o,
  output logic [PC_W-1:0] exp_npc_o,
  output logic [PC_W-1:0] dec_pc_o
);
  logic            vld_q;
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] npc_q;

  // shadow of the fetch/decode register: address and the guess made for it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      pc_q  <= '0;
      npc_q <= '0;
    end else begin
      vld_q <= !kill_i;
      pc_q  <= fetch_pc_i;
      npc_q <= fetch_npc_i;
    end
  end

  assign hit_o     = vld_q && dec_br_i;
  assign act_npc_o = dec_taken_i ? dec_tgt_i : pc_q + PC_W'(INSN_BYTES);
  assign exp_npc_o = npc_q;
  assign dec_pc_o  = pc_q;
endmodule

// File: rtl/bpf_nextpc_sel.sv
module bpf_nextpc_sel
  import bpf_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  fetch_mode_e     mode_i,
  input  logic [PC_W-1:0] seq_pc_i,
  input  logic            pred_taken_i,
  input  logic [PC_W-1:0] pred_tgt_i,
  input  logic            hit_i,
  input  logic            dec_taken_i,
  input  logic [PC_W-1:0] dec_tgt_i,
  input  logic [PC_W-1:0] act_npc_i,
  input  logic [PC_W-1:0] exp_npc_i,
  output logic [PC_W-1:0] fetch_npc_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            flush_o
);
  logic mispred;

  always_comb begin
    fetch_npc_o = seq_pc_i;
    next_pc_o   = seq_pc_i;
    flush_o     = 1'b0;
    mispred     = 1'b0;
    unique case (mode_i)
      FM_SLOT: begin
        if (hit_i && dec_taken_i) next_pc_o = dec_tgt_i;
      end
      default: begin
        if (pred_taken_i) fetch_npc_o = pred_tgt_i;
        mispred   = hit_i && (act_npc_i != exp_npc_i);
        next_pc_o = mispred ? act_npc_i : fetch_npc_o;
        flush_o   = mispred;
      end
    endcase
  end
endmodule

// File: rtl/bpf_fetch_ctrl.sv
module bpf_fetch_ctrl
  import bpf_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 4,
  parameter int INSN_BYTES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PC_W-1:0]  fetch_pc_i,
  input  logic             dec_br_i,
  input  logic [PC_W-1:0]  dec_tgt_i,
  input  logic             dec_taken_i,
  input  logic             slot_mode_i,
  output logic [PC_W-1:0]  next_pc_o,
  output logic             flush_o,
  output logic             upd_vld_o,
  output logic [IDX_W-1:0] upd_idx_o,
  output logic             upd_taken_o
);
  localparam int OFS_W = $clog2(INSN_BYTES);

  fetch_mode_e     mode;
  logic [PC_W-1:0] seq_pc;
  logic            pred_taken;
  logic [PC_W-1:0] pred_tgt;
  logic [PC_W-1:0] fetch_npc;
  logic            hit;
  logic [PC_W-1:0] act_npc;
  logic [PC_W-1:0] exp_npc;
  logic [PC_W-1:0] dec_pc;

  assign mode   = slot_mode_i ? FM_SLOT : FM_PREDICT;
  assign seq_pc = fetch_pc_i + PC_W'(INSN_BYTES);

  bpf_pred_table #(.PC_W(PC_W), .IDX_W(IDX_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_idx_i   (fetch_pc_i[OFS_W +: IDX_W]),
    .rd_taken_o (pred_taken),
    .rd_tgt_o   (pred_tgt),
    .wr_en_i    (hit),
    .wr_idx_i   (upd_idx_o),
    .wr_taken_i (dec_taken_i),
    .wr_tgt_i   (dec_tgt_i)
  );

  bpf_resolve #(.PC_W(PC_W), .INSN_BYTES(INSN_BYTES)) u_res (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fetch_pc_i  (fetch_pc_i),
    .fetch_npc_i (fetch_npc),
    .kill_i      (flush_o),
    .dec_br_i    (dec_br_i),
    .dec_tgt_i   (dec_tgt_i),
    .dec_taken_i (dec_taken_i),
    .hit_o       (hit),
    .act_npc_o   (act_npc),
    .exp_npc_o   (exp_npc),
    .dec_pc_o    (dec_pc)
  );

  bpf_nextpc_sel #(.PC_W(PC_W)) u_sel (
    .mode_i       (mode),
    .seq_pc_i     (seq_pc),
    .pred_taken_i (pred_taken),
    .pred_tgt_i   (pred_tgt),
    .hit_i        (hit),
    .dec_taken_i  (dec_taken_i),
    .dec_tgt_i    (dec_tgt_i),
    .act_npc_i    (act_npc),
    .exp_npc_i    (exp_npc),
    .fetch_npc_o  (fetch_npc),
    .next_pc_o    (next_pc_o),
    .flush_o      (flush_o)
  );

  assign upd_vld_o   = hit;
  assign upd_idx_o   = dec_pc[OFS_W +: IDX_W];
  assign upd_taken_o = dec_taken_i;
endmodule

// File: rtl/bpf_fetch_ctrl_chk.sv
module bpf_fetch_ctrl_chk #(
  parameter int PC_W       = 32,
  parameter int IDX_W      = 4,
  parameter int INSN_BYTES = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [PC_W-1:0]  fetch_pc_i,
  input logic             dec_br_i,
  input logic [PC_W-1:0]  dec_tgt_i,
  input logic             slot_mode_i,
  input logic [PC_W-1:0]  next_pc_o,
  input logic             flush_o,
  input logic             upd_vld_o,
  input logic [IDX_W-1:0] upd_idx_o,
  input logic             upd_taken_o
);
  localparam int OFS_W = $clog2(INSN_BYTES);

  assert_slot_no_flush_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slot_mode_i |-> !flush_o);

  assert_slot_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_mode_i && !dec_br_i) |-> next_pc_o == fetch_pc_i + PC_W'(INSN_BYTES));

  assert_upd_needs_branch_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_vld_o |-> dec_br_i);

  assert_upd_index_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_vld_o |-> upd_idx_o == $past(fetch_pc_i[OFS_W +: IDX_W]));

  assert_flush_on_resolve_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> upd_vld_o);

  assert_flush_to_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && upd_taken_o) |-> next_pc_o == dec_tgt_i);

  assert_flush_to_fallthru_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_o && !upd_taken_o) |-> next_pc_o == $past(fetch_pc_i) + PC_W'(INSN_BYTES));

  assert_flushed_slot_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> (!upd_vld_o && !flush_o));
endmodule

bind bpf_fetch_ctrl bpf_fetch_ctrl_chk #(
  .PC_W(PC_W), .IDX_W(IDX_W), .INSN_BYTES(INSN_BYTES)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .fetch_pc_i  (fetch_pc_i),
  .dec_br_i    (dec_br_i),
  .dec_tgt_i   (dec_tgt_i),
  .slot_mode_i (slot_mode_i),
  .next_pc_o   (next_pc_o),
  .flush_o     (flush_o),
  .upd_vld_o   (upd_vld_o),
  .upd_idx_o   (upd_idx_o),
  .upd_taken_o (upd_taken_o)
);

// File: tb/sim_bpf_fetch_ctrl.sv
`timescale 1ns/1ps
module sim_bpf_fetch_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_pc_i = '0;
  logic        dec_br_i = 1'b0;
  logic [31:0] dec_tgt_i = '0;
  logic        dec_taken_i = 1'b0;
  logic        slot_mode_i = 1'b0;
  logic [31:0] next_pc_o;
  logic        flush_o;
  logic        upd_vld_o;
  logic [3:0]  upd_idx_o;
  logic        upd_taken_o;

  int n_chk = 0;
  int n_fail = 0;

  bit          rbit [16];
  logic [31:0] rtgt [16];

  always #4 clk = ~clk;

  bpf_fetch_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .fetch_pc_i(fetch_pc_i), .dec_br_i(dec_br_i),
    .dec_tgt_i(dec_tgt_i), .dec_taken_i(dec_taken_i), .slot_mode_i(slot_mode_i),
    .next_pc_o(next_pc_o), .flush_o(flush_o), .upd_vld_o(upd_vld_o),
    .upd_idx_o(upd_idx_o), .upd_taken_o(upd_taken_o)
  );

  function automatic int idx_of(logic [31:0] pc);
    return int'((pc >> 2) & 32'hF);
  endfunction

  // prog 0: loop at 0x10C, back edge at 0x118
  // prog 1: loop at 0x10C, branch at 0x110 right behind it, aliasing branch at 0x14C
  // prog 2: same as prog 0, run in delay-slot mode
  function automatic bit is_br(int prog, logic [31:0] pc);
    if (pc == 32'h10C) return 1'b1;
    if (prog == 1) return (pc == 32'h110) || (pc == 32'h14C);
    return pc == 32'h118;
  endfunction

  function automatic logic [31:0] br_tgt(int prog, logic [31:0] pc);
    if (!is_br(prog, pc)) return 32'h0;
    if (pc == 32'h110) return 32'h140;
    return 32'h100;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input int prog, input int k, input int cycles);
    logic [31:0] pc, dpc, dnpc, seq, pnpc, act, exp_np, tgt;
    bit dv, pt, hit, tk, exp_fl;
    int iter, fi;
    string tag;
    rst_ni      = 1'b0;
    slot_mode_i = (prog == 2);
    fetch_pc_i  = 32'h10C;
    dec_br_i    = 1'b1;
    dec_tgt_i   = 32'h200;
    dec_taken_i = 1'b1;
    #2;
    check(next_pc_o == 32'h110, "R1", "reset next_pc", next_pc_o, 32'h110);
    check(flush_o == 1'b0, "R1", "reset flush", 32'(flush_o), 32'h0);
    check(upd_vld_o == 1'b0, "R1", "reset update", 32'(upd_vld_o), 32'h0);
    for (int i = 0; i < 16; i++) begin
      rbit[i] = 1'b0;
      rtgt[i] = '0;
    end
    @(negedge clk);
    rst_ni = 1'b1;
    #1;
    check(next_pc_o == 32'h110 && !flush_o && !upd_vld_o, "R1", "post-reset idle",
          next_pc_o, 32'h110);
    pc = 32'h100; dpc = '0; dnpc = '0; dv = 1'b0; iter = 0;
    for (int c = 0; c < cycles; c++) begin
      tgt = br_tgt(prog, dpc);
      tk  = is_br(prog, dpc) ? ((dpc == 32'h10C) ? (iter < k - 1) : 1'b1) : 1'b0;
      fetch_pc_i  = pc;
      dec_br_i    = is_br(prog, dpc);
      dec_tgt_i   = tgt;
      dec_taken_i = tk;
      seq  = pc + 32'd4;
      fi   = idx_of(pc);
      pt   = rbit[fi];
      pnpc = (prog != 2 && pt) ? rtgt[fi] : seq;
      hit  = dv && is_br(prog, dpc);
      act  = tk ? tgt : dpc + 32'd4;
      if (prog == 2) begin
        exp_fl = 1'b0;
        exp_np = (hit && tk) ? tgt : seq;
      end else begin
        exp_fl = hit && (act != dnpc);
        exp_np = exp_fl ? act : pnpc;
      end
      if (prog == 2) tag = "R8";
      else if (exp_fl) tag = "R5";
      else if (!dv && is_br(prog, dpc)) tag = "R7";
      else if (hit) tag = "R6";
      else if (prog == 1 && pc == 32'h10C) tag = "R11";
      else if (pt) tag = "R4";
      else tag = "R2";
      #3;
      check(next_pc_o == exp_np, tag, "next_pc", next_pc_o, exp_np);
      check(flush_o == exp_fl, tag, "flush", 32'(flush_o), 32'(exp_fl));
      check(upd_vld_o == hit, (prog == 2) ? "R9" : "R3", "upd_vld", 32'(upd_vld_o), 32'(hit));
      if (hit) begin
        check(upd_idx_o == 4'(idx_of(dpc)) && upd_taken_o == tk, (prog == 2) ? "R9" : "R3",
              "upd idx/taken", {27'h0, upd_taken_o, upd_idx_o},
              {27'h0, tk, 4'(idx_of(dpc))});
      end
      // r10_ loop shape: middle iterations hit, exit always misses
      if (prog == 0 && hit && dpc == 32'h10C && k >= 2) begin
        if (iter > 0 && iter < k - 1)
          check(!flush_o, "R10", "loop middle mispredict", 32'(flush_o), 32'h0);
        if (iter == k - 1)
          check(flush_o, "R10", "loop exit mispredict", 32'(flush_o), 32'h1);
        if (iter == 0)
          check(flush_o, "R10", "loop first mispredict", 32'(flush_o), 32'h1);
      end
      @(posedge clk);
      if (hit) begin
        rbit[idx_of(dpc)] = tk;
        if (tk) rtgt[idx_of(dpc)] = tgt;
        if (dpc == 32'h10C) iter = tk ? iter + 1 : 0;
      end
      dnpc = pnpc;
      dpc  = pc;
      dv   = !exp_fl;
      pc   = exp_np;
      @(negedge clk);
    end
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    for (int k = 1; k <= 5; k++) run(0, k, 150);
    for (int k = 1; k <= 4; k++) run(1, k, 150);
    for (int k = 1; k <= 4; k++) run(2, k, 150);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule